// File: doc/BRIEF.md
# Bus Master No-Response Watchdog

This block guards a bus master against a target that stops answering. While a transaction is open it counts clocks in which no data phase completes. If that count reaches the programmed limit, it requests a master abort and raises a system-error flag. A completed data phase restarts the count. A target retry does not restart it, so a target that retries without end is also aborted.

The limit is a 5-bit field that forms the upper five bits of an 8-bit terminal count. The abort therefore fires after the field value times 8 clocks, and a field of zero turns the watchdog off. The field is sampled while the bus is idle and stays fixed for the whole transaction. The master state machine uses the one-clock abort request to end the cycle. Software clears the sticky error flag through a separate input.

Top module: `bus_master_wdog`

## Requirements
- R1: While reset is low, and in the first clock after it, `abort_o` and `serr_o` are 0.
- R2: When the limit in force for a transaction is 0, no abort and no error are raised, however long the transaction stays open.
- R3: With limit L > 0, after L*8 consecutive clock edges with `xact_active_i` high and no completed data phase, `abort_o` is high during the clock that follows the L*8-th such edge and not before.
- R4: A completed data phase is an edge with `xact_active_i`, `data_xfer_i` high and `retry_i` low. It restarts the count from zero, and no abort follows it in the next clock.
- R5: An edge with `retry_i` high never restarts the count, even when `data_xfer_i` is also high.
- R6: `abort_o` is high for exactly one clock, and at most once per transaction.
- R7: `serr_o` rises in the same clock as `abort_o` and stays high until an edge with `err_clear_i` high. A new expiry on that same edge wins over the clear.
- R8: Clock edges with `xact_active_i` low do not count. Ending a transaction discards any partial count.
- R9: The limit in force is the value of `limit_i` at the last edge before the transaction opens. Changes to `limit_i` during a transaction have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| limit_i | input | 5 | Programmed limit, in units of 8 clocks; 0 disables |
| xact_active_i | input | 1 | High while the master owns an open transaction |
| data_xfer_i | input | 1 | Target ready: a data phase completes on this edge |
| retry_i | input | 1 | Target signals retry on this edge |
| err_clear_i | input | 1 | Clears the sticky system-error flag |
| abort_o | output | 1 | One-clock master-abort request |
| serr_o | output | 1 | Sticky system-error flag |

## Verification
The assertions check the local rules on every cycle: the abort is one clock wide, it comes with the error flag, the flag holds and clears correctly, and no abort follows an idle edge or a completed data phase. Only the bench scenarios can show the exact distance from the last data phase to the abort for a given limit. They also show that a zero limit never fires, that retries do not restart the count, and that a limit written mid-transaction is ignored.

// File: rtl/wdog_pkg.sv
// Package: shared widths for the bus master watchdog.
// Assumes the limit field forms the upper bits of the terminal count.
package wdog_pkg;
    localparam int unsigned LIMIT_W = 5;                 // programmed field width
    localparam int unsigned FRAC_W  = 3;                 // low bits below the field
    localparam int unsigned CNT_W   = LIMIT_W + FRAC_W;  // full counter width
endpackage

// File: rtl/wdog_limit_latch.sv
// Module: wdog_limit_latch
// Holds the limit used for the current transaction. It follows the
// programmed input while the bus is idle and freezes while a transaction
// is open. Assumes synchronous active-low reset.
module wdog_limit_latch #(
    parameter int unsigned LIMIT_W = wdog_pkg::LIMIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active_i,
    input  logic [LIMIT_W-1:0] limit_i,
    output logic [LIMIT_W-1:0] limit_o
);
    logic [LIMIT_W-1:0] lim_q;

    // Track the programmed value only outside a transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= '0;
        end else if (!active_i) begin
            lim_q <= limit_i;
        end
    end

    assign limit_o = lim_q;
endmodule

// File: rtl/wdog_count.sv
// Module: wdog_count
// Counts active clocks without a completed data phase and flags the edge
// on which the count reaches limit * 2**FRAC_W. It fires once per
// transaction. Assumes the limit input stays stable during a transaction.
module wdog_count #(
    parameter int unsigned LIMIT_W = wdog_pkg::LIMIT_W,
    parameter int unsigned FRAC_W  = wdog_pkg::FRAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active_i,
    input  logic               done_i,
    input  logic [LIMIT_W-1:0] limit_i,
    output logic               expire_o
);
    localparam int unsigned CNT_W = LIMIT_W + FRAC_W;

    logic [CNT_W-1:0] cnt_q;
    logic             fired_q;
    logic [CNT_W:0]   next_cnt;
    logic [CNT_W:0]   term;
    logic             enabled;

    // Terminal count: the field shifted up past the low counter bits.
    always_comb begin
        term     = {1'b0, limit_i, {FRAC_W{1'b0}}};
        next_cnt = {1'b0, cnt_q} + 1'b1;
        enabled  = (limit_i != '0);
        expire_o = active_i && enabled && !fired_q && !done_i && (next_cnt == term);
    end

    // Advance, restart or hold the count; remember a firing until idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
        end else if (!active_i) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
        end else if (expire_o) begin
            cnt_q   <= next_cnt[CNT_W-1:0];
            fired_q <= 1'b1;
        end else if (done_i) begin
            cnt_q   <= '0;
        end else if (!fired_q && enabled) begin
            cnt_q   <= next_cnt[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/wdog_err_flag.sv
// Module: wdog_err_flag
// Registers the abort pulse and keeps a sticky error flag. A set on
// the same edge as a clear wins. Assumes synchronous active-low reset.
module wdog_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic clear_i,
    output logic abort_o,
    output logic serr_o
);
    logic abort_q;
    logic serr_q;

    // One-clock abort request and sticky error, set over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_q <= 1'b0;
            serr_q  <= 1'b0;
        end else begin
            abort_q <= expire_i;
            if (expire_i) begin
                serr_q <= 1'b1;
            end else if (clear_i) begin
                serr_q <= 1'b0;
            end
        end
    end

    assign abort_o = abort_q;
    assign serr_o  = serr_q;
endmodule

// File: rtl/bus_master_wdog.sv
// Module: bus_master_wdog
// Top of the no-response watchdog. An edge with target ready and no retry
// counts as a completed data phase. Assumes all inputs are synchronous
// to clk.
module bus_master_wdog #(
    parameter int unsigned LIMIT_W = wdog_pkg::LIMIT_W,
    parameter int unsigned FRAC_W  = wdog_pkg::FRAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LIMIT_W-1:0] limit_i,
    input  logic               xact_active_i,
    input  logic               data_xfer_i,
    input  logic               retry_i,
    input  logic               err_clear_i,
    output logic               abort_o,
    output logic               serr_o
);
    logic [LIMIT_W-1:0] lim_cur;
    logic               phase_done;
    logic               expire;

    // A retry edge never completes a data phase.
    assign phase_done = data_xfer_i && !retry_i;

    wdog_limit_latch #(.LIMIT_W(LIMIT_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (xact_active_i),
        .limit_i  (limit_i),
        .limit_o  (lim_cur)
    );

    wdog_count #(.LIMIT_W(LIMIT_W), .FRAC_W(FRAC_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (xact_active_i),
        .done_i   (phase_done),
        .limit_i  (lim_cur),
        .expire_o (expire)
    );

    wdog_err_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire_i (expire),
        .clear_i  (err_clear_i),
        .abort_o  (abort_o),
        .serr_o   (serr_o)
    );
endmodule

// File: rtl/bus_master_wdog_chk.sv
// Module: bus_master_wdog_chk
// Cycle-level rules on the watchdog ports, attached by bind.
module bus_master_wdog_chk (
    input logic clk,
    input logic rst_n,
    input logic xact_active_i,
    input logic data_xfer_i,
    input logic retry_i,
    input logic err_clear_i,
    input logic abort_o,
    input logic serr_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!abort_o && !serr_o));

    // R6
    abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);

    // R7
    abort_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> serr_o);

    // R7
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(serr_o) |-> abort_o);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serr_o && !err_clear_i) |=> serr_o);

    // R7
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_clear_i |=> (!serr_o || abort_o));

    // R4
    done_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_active_i && data_xfer_i && !retry_i) |=> !abort_o);

    // R8
    idle_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xact_active_i |=> !abort_o);
endmodule

bind bus_master_wdog bus_master_wdog_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .xact_active_i (xact_active_i),
    .data_xfer_i   (data_xfer_i),
    .retry_i       (retry_i),
    .err_clear_i   (err_clear_i),
    .abort_o       (abort_o),
    .serr_o        (serr_o)
);

// File: tb/test_bus_master_wdog.sv
// Bench: directed corners plus seeded random traffic against a
// requirement-level model of the watchdog.
module test_bus_master_wdog;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] limit_i = '0;
    logic       xact_active_i = 1'b0;
    logic       data_xfer_i = 1'b0;
    logic       retry_i = 1'b0;
    logic       err_clear_i = 1'b0;
    logic       abort_o;
    logic       serr_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // model state
    logic [4:0] m_lim = '0;
    int         m_cnt = 0;
    bit         m_fired = 1'b0;
    bit         m_abort = 1'b0;
    bit         m_serr = 1'b0;

    always #2 clk = ~clk;

    bus_master_wdog i_bus_master_wdog (
        .clk(clk), .rst_n(rst_n), .limit_i(limit_i),
        .xact_active_i(xact_active_i), .data_xfer_i(data_xfer_i),
        .retry_i(retry_i), .err_clear_i(err_clear_i),
        .abort_o(abort_o), .serr_o(serr_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Requirement-level model of one clock edge.
    function automatic void model_edge(input logic act, input logic xf,
                                       input logic rt, input logic clr,
                                       input logic [4:0] lim_in);
        bit done_ph = xf && !rt;
        bit exp = act && (m_lim != 0) && !m_fired && !done_ph
                  && (m_cnt + 1 == int'(m_lim) * 8);
        m_abort = exp;
        if (exp) m_serr = 1'b1;
        else if (clr) m_serr = 1'b0;
        if (!act) begin
            m_cnt = 0; m_fired = 1'b0; m_lim = lim_in;
        end else if (exp) begin
            m_fired = 1'b1;
        end else if (done_ph) begin
            m_cnt = 0;
        end else if (!m_fired) begin
            m_cnt++;
        end
    endfunction

    // Drive one cycle, advance one edge, settle.
    task automatic step(input logic act, input logic xf, input logic rt, input logic clr);
        xact_active_i = act; data_xfer_i = xf; retry_i = rt; err_clear_i = clr;
        @(posedge clk);
        model_edge(act, xf, rt, clr, limit_i);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 abort in reset", abort_o, 1'b0);
        check("R1 serr in reset", serr_o, 1'b0);
        rst_n = 1'b1;
        idle(2);
        check("R1 abort after reset", abort_o, 1'b0);

        // R3, R6, R7: limit 1 -> abort after 8 edges
        limit_i = 5'd1; idle(2);
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
        check("R3 no early abort", abort_o, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        check("R3 abort at 8", abort_o, 1'b1);
        check("R7 serr with abort", serr_o, 1'b1);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        check("R6 pulse ends", abort_o, 1'b0);
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 30; i++) begin
                step(1'b1, 1'b0, 1'b0, 1'b0);
                if (abort_o) seen = 1'b1;
            end
            check("R6 once per transaction", seen, 1'b0);
        end
        check("R7 serr sticky", serr_o, 1'b1);
        idle(2);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check("R7 serr cleared", serr_o, 1'b0);

        // R2: limit 0 disables
        limit_i = 5'd0; idle(2);
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 300; i++) begin
                step(1'b1, 1'b0, 1'b0, 1'b0);
                if (abort_o || serr_o) seen = 1'b1;
            end
            check("R2 disabled never fires", seen, 1'b0);
        end
        idle(2);

        // R4: data phase restarts count, limit 2 -> 16
        limit_i = 5'd2; idle(2);
        for (int i = 0; i < 15; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        check("R4 no abort after data phase", abort_o, 1'b0);
        for (int i = 0; i < 15; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
        check("R4 count restarted", abort_o, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        check("R4 abort 16 after restart", abort_o, 1'b1);
        idle(2); step(1'b0, 1'b0, 1'b0, 1'b1);

        // R5: retry with ready does not restart, limit 1
        limit_i = 5'd1; idle(2);
        for (int i = 0; i < 7; i++) step(1'b1, 1'b1, 1'b1, 1'b0);
        check("R5 no early abort", abort_o, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        check("R5 retrying target aborted", abort_o, 1'b1);
        idle(2);

        // R7: expiry wins over clear on same edge
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b1);
        check("R7 set wins over clear", serr_o, 1'b1);
        idle(2); step(1'b0, 1'b0, 1'b0, 1'b1);
        check("R7 cleared again", serr_o, 1'b0);

        // R8: idle gaps discard partial count
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
        idle(10);
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
        check("R8 count discarded", abort_o, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        check("R8 fresh count fires", abort_o, 1'b1);
        idle(2); step(1'b0, 1'b0, 1'b0, 1'b1);

        // R9: limit change mid-transaction ignored
        limit_i = 5'd1; idle(2);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        limit_i = 5'd31;
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
        check("R9 no early abort", abort_o, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        check("R9 old limit used", abort_o, 1'b1);
        idle(2); step(1'b0, 1'b0, 1'b0, 1'b1);

        // Random traffic against the model (R3, R7)
        void'($urandom(32'd1234));
        for (int i = 0; i < 6000; i++) begin
            logic act;
            if (($urandom % 40) == 0) limit_i = (($urandom % 4) == 0) ? 5'($urandom) : 5'($urandom % 4);
            act = (($urandom % 50) != 0);
            step(act, (($urandom % 24) == 0), (($urandom % 6) == 0), (($urandom % 20) == 0));
            check("R3 random abort", abort_o, m_abort);
            check("R7 random serr", serr_o, m_serr);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule